// File: doc/BRIEF.md
# Double-Buffered Converter Data Register

This block is the digital front end of an 8-bit multiplying converter. A data word passes through two cascaded holding stages before it reaches the converter code outputs. The first stage is a staging register that is gated by a select line, an enable line and the first load strobe. The second stage is the code register, gated by the second load strobe and a transfer strobe. Both code outputs come from the code register: one carries the code and the other carries its complement, so together they model the pair of complementary current outputs. Each control line acts on its level. The stages are modelled as clock-enabled registers that behave like transparent latches sampled by the system clock.

Control lines can be tied to fixed levels to pick the mode. With the second strobe and the transfer line held active, the block is single-buffered. With every strobe held active, each bus value reaches the output one clock later. When the transfer line is shared by many copies of the block, all their outputs change in the same cycle. A timing checker counts system clocks. It raises sticky flags when a qualified first-stage strobe is too short, or when the bus changes during the hold window after that strobe is released.

Top module: `dbf_front`

## Requirements
- R1: While reset is asserted and just after it is released, both stages hold zero: `code_q` is 0, `code_qn` is 255, and both violation flags are low.
- R2: At a rising clock edge, the staging register loads `bus_d` only if `sel_n`=0, `latch_en`=1 and `ld1_n`=0. Otherwise it keeps its value.
- R3: At a rising clock edge, the code register loads only if `xfr_n`=0 and `ld2_n`=0. It takes the value the staging register holds after that edge, which is `bus_d` when the staging register also loads in that cycle. Otherwise the code register keeps its value, so a new word can be staged while the output still shows the old one.
- R4: With `sel_n`, `ld1_n`, `ld2_n` and `xfr_n` all 0 and `latch_en`=1, `code_q` equals the `bus_d` value sampled at the previous rising edge.
- R5: Bit 0 is the least significant bit. `code_qn` equals 255 minus `code_q`, so the sum of the two outputs is always 255.
- R6: With `latch_en`=0, changes on the bus and on `sel_n`/`ld1_n` never alter the staged word, even when a transfer follows.
- R7: If the qualified first-stage strobe is released after being active for fewer than MIN_W_CYC consecutive edges, `err_width` rises and stays high until reset. A strobe active for MIN_W_CYC edges or more leaves it low.
- R8: If `bus_d` differs from the captured word at any of the HOLD_CYC edges that start at the first edge with the strobe released, `err_hold` rises and stays high until reset. A change after that window leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Data word, bit 0 least significant |
| sel_n | input | 1 | Device select, active low |
| latch_en | input | 1 | Staging enable, active high |
| ld1_n | input | 1 | First-stage load strobe, active low |
| ld2_n | input | 1 | Second-stage load strobe, active low |
| xfr_n | input | 1 | Transfer strobe, active low |
| code_q | output | 8 | Code register contents |
| code_qn | output | 8 | Complement of the code (255 minus code) |
| err_width | output | 1 | Sticky short-strobe flag |
| err_hold | output | 1 | Sticky hold-window flag |

## Verification
The bench tries all eight combinations of the three first-stage qualifiers. A design that decoded the enable with the wrong polarity, or dropped one qualifier, would load on an unqualified combination, and the stale expected output would expose it. A full 256-code sweep in the pass-through configuration checks the one-cycle latency and the complement. If the second stage copied the old staged word instead of the word loaded in the same cycle, the output would lag by two cycles. If the complement were wrong, the sum would differ from 255. The checker is tested exactly at the strobe length MIN_W_CYC-1/MIN_W_CYC and at the edges just inside and just outside the hold window, which catches off-by-one errors in either counter.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef struct packed {
    logic sel_n;
    logic latch_en;
    logic ld1_n;
    logic ld2_n;
    logic xfr_n;
  } dbf_ctrl_t;

  function automatic logic stage_qual(input dbf_ctrl_t c);
    return (~c.sel_n) & c.latch_en & (~c.ld1_n);
  endfunction

  function automatic logic code_qual(input dbf_ctrl_t c);
    return (~c.ld2_n) & (~c.xfr_n);
  endfunction

endpackage

// File: rtl/dbf_hold_reg.sv
module dbf_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/dbf_timing_chk.sv
module dbf_timing_chk #(
  parameter int W         = 8,
  parameter int MIN_W_CYC = 45,
  parameter int HOLD_CYC  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] bus,
  input  logic [W-1:0] held,
  output logic         err_width,
  output logic         err_hold
);

  localparam int WCW = $clog2(MIN_W_CYC + 1);
  localparam int HCW = $clog2(HOLD_CYC + 1);
  localparam logic [WCW-1:0] MIN_W_L  = WCW'(MIN_W_CYC);
  localparam logic [HCW-1:0] HOLD_L1  = HCW'(HOLD_CYC - 1);

  logic           strobe_d;
  logic [WCW-1:0] wcnt, wcnt_nxt;
  logic [HCW-1:0] hleft, hleft_nxt;
  logic           ew_nxt, eh_nxt;
  logic           release_e, in_win;

  always_comb begin
    release_e = strobe_d & ~strobe;
    in_win    = release_e | ((hleft != '0) & ~strobe);

    wcnt_nxt = '0;
    if (strobe) wcnt_nxt = (wcnt == MIN_W_L) ? wcnt : wcnt + 1'b1;

    hleft_nxt = '0;
    if (!strobe) begin
      if (release_e)           hleft_nxt = HOLD_L1;
      else if (hleft != '0)    hleft_nxt = hleft - 1'b1;
    end

    ew_nxt = err_width | (release_e & (wcnt < MIN_W_L));
    eh_nxt = err_hold  | (in_win & (bus != held));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d  <= 1'b0;
      wcnt      <= '0;
      hleft     <= '0;
      err_width <= 1'b0;
      err_hold  <= 1'b0;
    end else begin
      strobe_d  <= strobe;
      wcnt      <= wcnt_nxt;
      hleft     <= hleft_nxt;
      err_width <= ew_nxt;
      err_hold  <= eh_nxt;
    end
  end

  // R7: width flag is sticky
  assert_width_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_width |=> err_width);

  // R8: hold flag is sticky
  assert_hold_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_hold |=> err_hold);

  // R8: a hold fault is never recorded while the strobe is active
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> $stable(err_hold));

  // R7: a width fault only appears on a release edge
  assert_width_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe | ~strobe_d) |=> $stable(err_width));

endmodule

// File: rtl/dbf_front.sv
module dbf_front #(
  parameter int DW        = 8,
  parameter int MIN_W_CYC = 45,
  parameter int HOLD_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_d,
  input  logic          sel_n,
  input  logic          latch_en,
  input  logic          ld1_n,
  input  logic          ld2_n,
  input  logic          xfr_n,
  output logic [DW-1:0] code_q,
  output logic [DW-1:0] code_qn,
  output logic          err_width,
  output logic          err_hold
);
  import dbf_pkg::*;

  localparam logic [DW-1:0] FULL = {DW{1'b1}};

  dbf_ctrl_t     ctrl;
  logic          ld_stage, ld_code;
  logic [DW-1:0] stage_q, stage_view;

  always_comb begin
    ctrl       = '{sel_n: sel_n, latch_en: latch_en, ld1_n: ld1_n,
                   ld2_n: ld2_n, xfr_n: xfr_n};
    ld_stage   = stage_qual(ctrl);
    ld_code    = code_qual(ctrl);
    stage_view = ld_stage ? bus_d : stage_q;
  end

  dbf_hold_reg #(.W(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .en(ld_stage), .d(bus_d), .q(stage_q)
  );

  dbf_hold_reg #(.W(DW)) u_code (
    .clk(clk), .rst_n(rst_n), .en(ld_code), .d(stage_view), .q(code_q)
  );

  always_comb code_qn = FULL - code_q;

  dbf_timing_chk #(.W(DW), .MIN_W_CYC(MIN_W_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(ld_stage), .bus(bus_d), .held(stage_q),
    .err_width(err_width), .err_hold(err_hold)
  );

  // R5: outputs always sum to full scale
  assert_comp_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q + code_qn) == FULL);

  // R4: pass-through follows the bus one cycle later
  assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && latch_en && !ld1_n && !ld2_n && !xfr_n) |=> code_q == $past(bus_d));

  // R3: no transfer leaves the output unchanged
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ld2_n && !xfr_n) |=> $stable(code_q));

  // R3: transfer alone copies the staged word
  assert_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_code && !ld_stage) |=> code_q == $past(stage_q));

  // R6: with the enable low the staged word is frozen
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(stage_q));

endmodule

// File: tb/sim_dbf_front.sv
module sim_dbf_front;
  localparam int MINW = 45;
  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_d;
  logic       sel_n, latch_en, ld1_n, ld2_n, xfr_n;
  logic [7:0] code_q, code_qn;
  logic       err_width, err_hold;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbf_front #(.DW(8), .MIN_W_CYC(MINW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .sel_n(sel_n), .latch_en(latch_en),
    .ld1_n(ld1_n), .ld2_n(ld2_n), .xfr_n(xfr_n), .code_q(code_q),
    .code_qn(code_qn), .err_width(err_width), .err_hold(err_hold)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctl(input logic s, input logic e, input logic w1,
                     input logic w2, input logic x);
    sel_n = s; latch_en = e; ld1_n = w1; ld2_n = w2; xfr_n = x;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctl(1, 0, 1, 1, 1);
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  // qualified first-stage pulse of n edges, then released with bus held
  task automatic pulse(input logic [7:0] v, input int n, input int after);
    bus_d = v;
    sel_n = 0; latch_en = 1; ld1_n = 0;
    tick(n);
    ld1_n = 1;
    tick(after);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    bus_d = 8'h00;
    do_reset();
    // R1 reset state
    chk("R1 code_q", code_q, 0);
    chk("R1 code_qn", code_qn, 255);
    chk("R1 err_width", err_width, 0);
    chk("R1 err_hold", err_hold, 0);

    // R4/R5 pass-through sweep over every code
    ctl(0, 1, 0, 0, 0);
    for (int v = 0; v < 256; v++) begin
      bus_d = 8'(v);
      tick(1);
      chk("R4 follow", code_q, v);
      chk("R5 complement", code_qn, 255 - v);
    end
    ld1_n = 1;
    tick(HOLD + 1);
    held = 8'd255;

    // R2/R6 single-buffered: every combination of the three qualifiers
    ld2_n = 0; xfr_n = 0;
    for (int c = 0; c < 8; c++) begin
      logic [7:0] v;
      logic s, e, w;
      v = 8'((c * 37 + 11) & 255);
      s = c[0]; e = c[1]; w = c[2];
      bus_d = v;
      sel_n = s; latch_en = e; ld1_n = w;
      tick(MINW);
      ld1_n = 1;
      tick(HOLD + 1);
      if (!s && e && !w) held = v;
      chk(e ? "R2 qualifier" : "R6 enable low", code_q, held);
    end

    // R3 double-buffered: stage a word while output keeps the old one
    ctl(1, 1, 1, 1, 1);
    tick(1);
    pulse(8'hA5, MINW, HOLD + 1);
    chk("R3 staged not shown", code_q, held);
    ctl(1, 1, 1, 0, 1); tick(2);
    chk("R3 ld2 alone", code_q, held);
    ctl(1, 1, 1, 1, 0); tick(2);
    chk("R3 xfr alone", code_q, held);
    ctl(1, 1, 1, 0, 0); tick(1);
    chk("R3 transfer", code_q, 8'hA5);
    ctl(1, 1, 1, 1, 1); tick(1);

    // R6 freeze: bus and strobes toggle with enable low, then transfer
    ctl(0, 0, 0, 1, 1);
    for (int k = 0; k < 20; k++) begin
      bus_d = 8'(k * 13);
      tick(1);
    end
    ctl(0, 0, 0, 0, 0); tick(2);
    chk("R6 frozen after transfer", code_q, 8'hA5);
    ctl(1, 1, 1, 1, 1); tick(1);
    chk("R7 no false width", err_width, 0);
    chk("R8 no false hold", err_hold, 0);

    // R7 width boundary
    pulse(8'h3C, MINW, HOLD + 1);
    chk("R7 exact min", err_width, 0);
    pulse(8'h3C, MINW - 1, HOLD + 1);
    chk("R7 one short", err_width, 1);
    chk("R7 hold untouched", err_hold, 0);
    tick(3);
    chk("R7 sticky", err_width, 1);

    // R8 hold window boundary
    do_reset();
    bus_d = 8'h5A; tick(1);
    pulse(8'h5A, MINW, HOLD);
    bus_d = 8'h5B; tick(2);
    chk("R8 change after window", err_hold, 0);
    pulse(8'h77, MINW, 1);
    bus_d = 8'h78; tick(2);
    chk("R8 change inside window", err_hold, 1);
    chk("R8 width untouched", err_width, 0);
    bus_d = 8'h00; tick(HOLD + 2);
    chk("R8 sticky", err_hold, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule